// File: doc/BRIEF.md
# Bayer Color Gain Steering Controller

This block sits in the front end of a color image sensor. It holds four programmable 6-bit gain codes, and on every pixel clock it picks the one that fits the color of the pixel now being sampled. The chosen code goes to a per-pixel gain stage further down the path. A 2-bit index beside the code tells which register was picked. Within a line the pick alternates between two registers, one pair per line type. The line type follows the horizontal, vertical and field sync strobes, which arrive asynchronously and are synchronized inside the block.

Two sensor layouts are covered. Progressive mode alternates line types on each line and uses the vertical sync to restart the pattern. Interlaced mode takes the line type from the field sync level, so both fields start on the right color row. Gain writes go to a shadow copy and are committed at the next line start, so a gain never changes partway through a line.

Top module: `bayer_gain_steer`

## Requirements
- R1: While reset is asserted and right after it is released, `sel_o` is 0 and every gain register reads 0, so `gain_o` is 0.
- R2: Each of the four registers holds a 6-bit code (0 to 63), written with `wr_en`, `wr_addr` and `wr_data`. `gain_o` always equals the committed code of the register that `sel_o` names.
- R3: In an active mode the index is `sel_o = {line, phase}`. Within a line `phase` flips on every clock, so a "01" line (line=0) gives 0,1,0,1 and a "23" line (line=1) gives 2,3,2,3.
- R4: A falling edge on `hsync_i` restarts the phase at the even register of the pair. Every sync transition takes effect on the third rising clock edge after it reaches the input: two synchronizer stages, then the edge register.
- R5: In progressive mode (`mode_i` = 3'b001), each `hsync_i` falling edge toggles the line type, unless R6 applies.
- R6: In progressive mode, a `vsync_i` falling edge forces line type "01" at once. The next `hsync_i` falling edge then keeps "01" instead of toggling. When `vsync_i` and `hsync_i` fall in the same cycle, that line is a "01" line and the following one toggles as usual.
- R7: In progressive mode, `fsync_i` has no effect on the line type.
- R8: In interlaced mode (`mode_i` = 3'b010), a falling `fsync_i` (odd field) forces line type "01", and a rising `fsync_i` (even field) forces "23".
- R9: In interlaced mode, each `hsync_i` falling edge sets the line type from the `fsync_i` level: low gives "01" (start at register 0), high gives "23" (start at register 2). There is no toggling between lines.
- R10: Any other `mode_i` value, including 3'b000 (off), holds `sel_o` at 0 and clears the steering state.
- R11: A gain write changes `gain_o` only after the next `hsync_i` falling edge, in every mode. A write made in the same cycle as that edge waits for the edge after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hsync_i | input | 1 | Horizontal sync strobe, asynchronous, falling edge marks a line start |
| vsync_i | input | 1 | Vertical sync strobe, asynchronous |
| fsync_i | input | 1 | Field sync level, asynchronous, low = odd field |
| mode_i | input | 3 | Steering mode: 001 progressive, 010 interlaced, others hold register 0 |
| wr_en | input | 1 | Gain register write strobe |
| wr_addr | input | 2 | Gain register number for the write |
| wr_data | input | 6 | Gain code to write |
| gain_o | output | 6 | Selected gain code for the current pixel |
| sel_o | output | 2 | Number of the selected gain register |

## Verification
The bench builds the block with its default parameters: 6-bit gain codes and two synchronizer stages. With these values the three-edge sync latency is fixed and small, so each line start can be driven and the first two pixels of the line checked exactly. The full code range, including 63, can also be written and read back through `gain_o`. The directed sequences cover simultaneous and separate vertical and horizontal edges, field edges in both modes, and writes made partway through a line.

// File: rtl/bgs_pkg.sv
package bgs_pkg;
  localparam int MODE_W = 3;
  localparam int NREG   = 4;
  localparam int IDX_W  = $clog2(NREG);

  typedef enum logic [MODE_W-1:0] {
    STEER_OFF  = 3'd0,
    STEER_PROG = 3'd1,
    STEER_INTL = 3'd2
  } steer_mode_e;
endpackage

// File: rtl/bgs_sync_edge.sv
// Multi-bit synchronizer; each bit gets its own flop chain plus a history flop
// so the caller can form whichever edges it needs.
module bgs_sync_edge #(
  parameter int       N       = 3,
  parameter int       STAGES  = 2,
  parameter logic [N-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] cur,
  output logic [N-1:0] prev
);
  for (genvar b = 0; b < N; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    logic              hist_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain_q <= {STAGES{RST_VAL[b]}};
        hist_q  <= RST_VAL[b];
      end else begin
        chain_q <= {chain_q[STAGES-2:0], din[b]};
        hist_q  <= chain_q[STAGES-1];
      end
    end

    assign cur[b]  = chain_q[STAGES-1];
    assign prev[b] = hist_q;
  end
endmodule

// File: rtl/bgs_gain_bank.sv
// Shadow and committed gain registers; commit happens at a line start.
module bgs_gain_bank #(
  parameter int GAIN_W = 6,
  parameter int NREG   = 4,
  localparam int AW    = $clog2(NREG)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [AW-1:0]                wr_addr,
  input  logic [GAIN_W-1:0]            wr_data,
  input  logic                         commit,
  output logic [NREG-1:0][GAIN_W-1:0]  live
);
  logic [NREG-1:0][GAIN_W-1:0] shadow_q, shadow_d;
  logic [NREG-1:0][GAIN_W-1:0] live_q;

  always_comb begin
    shadow_d = shadow_q;
    for (int i = 0; i < NREG; i++) begin
      if (wr_en && (wr_addr == AW'(i))) shadow_d[i] = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
    end else begin
      shadow_q <= shadow_d;
    end
  end

  // Clock enable: committed set loads only on a line start.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= '0;
    end else if (commit) begin
      live_q <= shadow_q;
    end
  end

  assign live = live_q;
endmodule

// File: rtl/bgs_steer.sv
// Line-type and pixel-phase sequencer.
module bgs_steer
  import bgs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode,
  input  logic              hs_fall,
  input  logic              vs_fall,
  input  logic              fs_fall,
  input  logic              fs_rise,
  input  logic              fs_lvl,
  output logic [IDX_W-1:0]  sel
);
  logic line_q, line_d;
  logic phase_q, phase_d;
  logic hold_q, hold_d;   // vertical restart seen, next line keeps "01"

  always_comb begin
    line_d  = line_q;
    phase_d = ~phase_q;
    hold_d  = hold_q;
    unique case (steer_mode_e'(mode))
      STEER_PROG: begin
        if (vs_fall) begin
          line_d = 1'b0;
          hold_d = ~hs_fall;
        end else if (hs_fall) begin
          line_d = hold_q ? 1'b0 : ~line_q;
          hold_d = 1'b0;
        end
        if (hs_fall) phase_d = 1'b0;
      end
      STEER_INTL: begin
        hold_d = 1'b0;
        if (fs_fall || fs_rise || hs_fall) line_d = fs_lvl;
        if (hs_fall) phase_d = 1'b0;
      end
      default: begin
        line_d  = 1'b0;
        phase_d = 1'b0;
        hold_d  = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q  <= 1'b0;
      phase_q <= 1'b0;
      hold_q  <= 1'b0;
    end else begin
      line_q  <= line_d;
      phase_q <= phase_d;
      hold_q  <= hold_d;
    end
  end

  assign sel = {line_q, phase_q};
endmodule

// File: rtl/bayer_gain_steer.sv
module bayer_gain_steer
  import bgs_pkg::*;
#(
  parameter int GAIN_W      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hsync_i,
  input  logic              vsync_i,
  input  logic              fsync_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_addr,
  input  logic [GAIN_W-1:0] wr_data,
  output logic [GAIN_W-1:0] gain_o,
  output logic [IDX_W-1:0]  sel_o
);
  localparam int NSYNC = 3;  // bit 0 hsync, 1 vsync, 2 fsync

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_pipe_q;
  logic       rst_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_ok = rst_pipe_q[1];

  logic [NSYNC-1:0] sy_cur, sy_prev;
  bgs_sync_edge #(
    .N      (NSYNC),
    .STAGES (SYNC_STAGES),
    .RST_VAL('1)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_ok),
    .din  ({fsync_i, vsync_i, hsync_i}),
    .cur  (sy_cur),
    .prev (sy_prev)
  );

  logic hs_fall, vs_fall, fs_fall, fs_rise, fs_lvl;
  assign hs_fall = sy_prev[0] & ~sy_cur[0];
  assign vs_fall = sy_prev[1] & ~sy_cur[1];
  assign fs_fall = sy_prev[2] & ~sy_cur[2];
  assign fs_rise = ~sy_prev[2] & sy_cur[2];
  assign fs_lvl  = sy_cur[2];

  logic [NREG-1:0][GAIN_W-1:0] gain_live;
  bgs_gain_bank #(
    .GAIN_W(GAIN_W),
    .NREG  (NREG)
  ) u_bank (
    .clk    (clk),
    .rst_n  (rst_ok),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .commit (hs_fall),
    .live   (gain_live)
  );

  logic [IDX_W-1:0] sel_w;
  bgs_steer u_steer (
    .clk    (clk),
    .rst_n  (rst_ok),
    .mode   (mode_i),
    .hs_fall(hs_fall),
    .vs_fall(vs_fall),
    .fs_fall(fs_fall),
    .fs_rise(fs_rise),
    .fs_lvl (fs_lvl),
    .sel    (sel_w)
  );

  assign sel_o  = sel_w;
  assign gain_o = gain_live[sel_w];
endmodule

// File: rtl/bgs_checker.sv
module bgs_checker #(
  parameter int GAIN_W = 6,
  parameter int NREG   = 4
) (
  input logic                        clk,
  input logic                        rst_ok,
  input logic [2:0]                  mode_i,
  input logic                        hs_fall,
  input logic                        vs_fall,
  input logic                        fs_fall,
  input logic                        fs_rise,
  input logic                        fs_lvl,
  input logic [1:0]                  sel_o,
  input logic [NREG-1:0][GAIN_W-1:0] gain_live
);
  logic is_prog, is_intl, is_act;
  assign is_prog = (mode_i == 3'd1);
  assign is_intl = (mode_i == 3'd2);
  assign is_act  = is_prog | is_intl;

  assert_pixel_alt_R3: assert property (@(posedge clk) disable iff (!rst_ok)
    (is_act && !hs_fall) |=> (sel_o[0] != $past(sel_o[0])));

  assert_line_even_start_R4: assert property (@(posedge clk) disable iff (!rst_ok)
    (is_act && hs_fall) |=> (sel_o[0] == 1'b0));

  assert_vs_restart_R6: assert property (@(posedge clk) disable iff (!rst_ok)
    (is_prog && vs_fall) |=> (sel_o[1] == 1'b0));

  assert_odd_field_R8: assert property (@(posedge clk) disable iff (!rst_ok)
    (is_intl && fs_fall) |=> (sel_o[1] == 1'b0));

  assert_even_field_R8: assert property (@(posedge clk) disable iff (!rst_ok)
    (is_intl && fs_rise) |=> (sel_o[1] == 1'b1));

  assert_field_line_R9: assert property (@(posedge clk) disable iff (!rst_ok)
    (is_intl && hs_fall) |=> (sel_o[1] == $past(fs_lvl)));

  assert_idle_zero_R10: assert property (@(posedge clk) disable iff (!rst_ok)
    (!is_act) |=> (sel_o == 2'd0));

  assert_gain_frozen_R11: assert property (@(posedge clk) disable iff (!rst_ok)
    (!hs_fall) |=> $stable(gain_live));
endmodule

bind bayer_gain_steer bgs_checker #(
  .GAIN_W(GAIN_W),
  .NREG  (bgs_pkg::NREG)
) u_bgs_checker (
  .clk      (clk),
  .rst_ok   (rst_ok),
  .mode_i   (mode_i),
  .hs_fall  (hs_fall),
  .vs_fall  (vs_fall),
  .fs_fall  (fs_fall),
  .fs_rise  (fs_rise),
  .fs_lvl   (fs_lvl),
  .sel_o    (sel_o),
  .gain_live(gain_live)
);

// File: tb/bayer_gain_steer_bench.sv
`timescale 1ns/1ps
module bayer_gain_steer_bench;
  logic       clk;
  logic       rst_n;
  logic       hsync_i, vsync_i, fsync_i;
  logic [2:0] mode_i;
  logic       wr_en;
  logic [1:0] wr_addr;
  logic [5:0] wr_data;
  logic [5:0] gain_o;
  logic [1:0] sel_o;

  int checks = 0;
  int fails  = 0;
  int shadow [4];
  int act    [4];
  bit done   = 0;

  bayer_gain_steer u_bayer_gain_steer (
    .clk(clk), .rst_n(rst_n),
    .hsync_i(hsync_i), .vsync_i(vsync_i), .fsync_i(fsync_i),
    .mode_i(mode_i), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .gain_o(gain_o), .sel_o(sel_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, actual, expected, $time);
    end
  endtask

  task automatic wr(input int a, input int d);
    wr_en = 1'b1; wr_addr = 2'(a); wr_data = 6'(d);
    step(1);
    wr_en = 1'b0;
    shadow[a] = d;
  endtask

  // One line start; checks the first two pixels of the new line.
  task automatic hs_line(input int ln, input string req);
    hsync_i = 1'b0;
    step(3);
    for (int i = 0; i < 4; i++) act[i] = shadow[i];
    chk(req, sel_o, ln*2);
    chk({req, "_R2"}, gain_o, act[ln*2]);
    step(1);
    chk({req, "_R3"}, sel_o, ln*2+1);
    chk({req, "_R2"}, gain_o, act[ln*2+1]);
    hsync_i = 1'b1;
    step(4);
  endtask

  task automatic t_reset();
    chk("R1 sel", sel_o, 0);
    chk("R1 gain", gain_o, 0);
  endtask

  task automatic t_off_and_defer();
    mode_i = 3'd0;
    hsync_i = 1'b0; step(3);
    chk("R10 off", sel_o, 0);
    step(1);
    chk("R10 off", sel_o, 0);
    hsync_i = 1'b1; step(4);
    wr(0, 11); wr(1, 22); wr(2, 33); wr(3, 63);
    chk("R11 before commit", gain_o, 0);
    hsync_i = 1'b0; step(3);
    for (int i = 0; i < 4; i++) act[i] = shadow[i];
    chk("R11 commit", gain_o, 11);
    hsync_i = 1'b1; step(4);
  endtask

  task automatic t_progressive();
    mode_i = 3'd1;
    vsync_i = 1'b0; hsync_i = 1'b0;
    step(3);
    chk("R6 joint start", sel_o, 0);
    step(1);
    chk("R3 pixel", sel_o, 1);
    chk("R2 gain", gain_o, 22);
    step(1);
    chk("R3 pixel", sel_o, 0);
    vsync_i = 1'b1; hsync_i = 1'b1; step(4);
    hs_line(1, "R5");
    hs_line(0, "R5");
    hs_line(1, "R5");
    chk("R2 top code", gain_o, (sel_o == 2'd3) ? 63 : 33);
  endtask

  task automatic t_vs_alone();
    vsync_i = 1'b0; step(3);
    chk("R6 vs alone", sel_o[1], 0);
    vsync_i = 1'b1; step(4);
    hs_line(0, "R6");
    hs_line(1, "R5");
  endtask

  task automatic t_fsync_prog();
    fsync_i = 1'b0; step(4);
    chk("R7 fs fall", sel_o[1], 1);
    fsync_i = 1'b1; step(4);
    chk("R7 fs rise", sel_o[1], 1);
  endtask

  task automatic t_interlaced();
    mode_i = 3'd2;
    fsync_i = 1'b0; step(3);
    chk("R8 odd", sel_o[1], 0);
    fsync_i = 1'b1; step(3);
    chk("R8 even", sel_o[1], 1);
    hs_line(1, "R9");
    hs_line(1, "R9");
    fsync_i = 1'b0; step(4);
    hs_line(0, "R9");
    hs_line(0, "R9");
  endtask

  task automatic t_midline_write();
    wr(0, 50);
    if (sel_o[0]) step(1);
    chk("R11 midline", gain_o, 11);
    hs_line(0, "R11");
  endtask

  task automatic t_undefined();
    mode_i = 3'd7; step(1);
    chk("R10 undef", sel_o, 0);
    hsync_i = 1'b0; step(3);
    chk("R10 undef", sel_o, 0);
    step(1);
    chk("R10 undef", sel_o, 0);
    hsync_i = 1'b1; step(4);
    for (int i = 0; i < 4; i++) act[i] = shadow[i];
    mode_i = 3'd3; step(2);
    chk("R10 code3", sel_o, 0);
    chk("R10 gain", gain_o, act[0]);
  endtask

  initial begin
    rst_n = 1'b0; hsync_i = 1'b1; vsync_i = 1'b1; fsync_i = 1'b1;
    mode_i = 3'd0; wr_en = 1'b0; wr_addr = 2'd0; wr_data = 6'd0;
    for (int i = 0; i < 4; i++) begin shadow[i] = 0; act[i] = 0; end
    step(4);
    t_reset();
    rst_n = 1'b1;
    step(3);
    t_reset();
    t_off_and_defer();
    t_progressive();
    t_vs_alone();
    t_fsync_prog();
    t_interlaced();
    t_midline_write();
    t_undefined();
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule